// File: doc/BRIEF.md
# QPSK Symbol Mapper with Pilot Insertion

This block turns a stream of 32-bit payload words into complex 4-QAM symbols. Each word is unpacked two bits at a time, starting at the most significant end. The first bit of each pair becomes the real (I) level and the second becomes the imaginary (Q) level. One word therefore yields sixteen symbols. Each bit is represented as a signed fixed-point level of about ±0.707. A 0 bit gives the positive level and a 1 bit gives the negative level.

A second input carries single reference bits. These are paired in the same way to build pilot symbols. The output stream follows a fixed repeating pattern: one pilot symbol, then five payload symbols. When the pilot for the current slot is not yet complete, the output waits instead of sending payload ahead of it. All three streams use valid/ready handshakes, and an output flag marks pilot symbols. The block feeds a later subcarrier-mapping and IFFT stage.

Top module: `qpsk_pilot_mux`

## Requirements
- R1: Within a word, symbol k (k = 0..15) takes word bit 31-2k as its I bit and word bit 30-2k as its Q bit, so bits 31/30 form the first symbol and bits 1/0 form the sixteenth.
- R2: A bit value 0 is output as +23170 and a bit value 1 is output as -23170 (signed 16-bit Q1.15), on both sym_re and sym_im.
- R3: A pilot symbol takes the first reference bit accepted after the previous pilot as its I bit and the second as its Q bit, and it is flagged with sym_is_pilot = 1; payload symbols carry sym_is_pilot = 0.
- R4: Output symbols follow the repeating order pilot, payload ×5, starting with a pilot. Payload symbols continue across word boundaries in the order the words were accepted.
- R5: word_ready is 1 exactly when every symbol of the last accepted word has been transferred. It returns to 1 in the cycle after the sixteenth transfer.
- R6: When a pilot slot is due and fewer than two reference bits are held, sym_valid stays 0, even if payload is available; no payload symbol is sent in the pilot's place.
- R7: While sym_valid = 1 and sym_ready = 0, sym_valid, sym_re, sym_im and sym_is_pilot hold their values into the next cycle.
- R8: A synchronous reset (rst = 1 at a rising edge) discards any held word and any partial or complete pilot bits, and restarts the pattern at the pilot slot. After reset, sym_valid = 0, word_ready = 1 and ref_ready = 1.
- R9: ref_ready is 0 while two reference bits are held. It returns to 1 in the cycle after the pilot built from them is transferred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| word_valid | input | 1 | Payload word offered |
| word_data | input | 32 | Payload word |
| word_ready | output | 1 | Payload word accepted when high with word_valid |
| ref_valid | input | 1 | Reference bit offered |
| ref_bit | input | 1 | Reference bit |
| ref_ready | output | 1 | Reference bit accepted when high with ref_valid |
| sym_valid | output | 1 | Output symbol present |
| sym_re | output | 16 | Real part, signed Q1.15 |
| sym_im | output | 16 | Imaginary part, signed Q1.15 |
| sym_is_pilot | output | 1 | High when the output symbol is a pilot |
| sym_ready | input | 1 | Downstream takes the symbol when high with sym_valid |

## Verification
The hold checks assume that the downstream side only drops sym_ready and never expects a symbol to be withdrawn. They also assume that the input streams only change their offered values on the cycle after a transfer. The stimulus keeps word_valid and ref_valid, and their data, steady until a transfer. It drives sym_ready with an irregular pattern so that stalls fall on pilot and payload symbols alike. The reference stream is held back for a long gap while payload is waiting, so the pilot stall is exercised against a ready payload word.

// File: rtl/qpsk_pilot_mux.sv
module qpsk_pilot_mux #(
  parameter int WORD_W   = 32,
  parameter int LVL_W    = 16,
  parameter int LEVEL    = 23170,
  parameter int DATA_RUN = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              word_valid,
  input  logic [WORD_W-1:0] word_data,
  output logic              word_ready,
  input  logic              ref_valid,
  input  logic              ref_bit,
  output logic              ref_ready,
  output logic              sym_valid,
  output logic [LVL_W-1:0]  sym_re,
  output logic [LVL_W-1:0]  sym_im,
  output logic              sym_is_pilot,
  input  logic              sym_ready
);
  localparam int SYMS   = WORD_W / 2;
  localparam int CNT_W  = $clog2(SYMS + 1);
  localparam int SLOT_W = $clog2(DATA_RUN + 1);
  localparam logic [LVL_W-1:0] POS = LVL_W'(LEVEL);
  localparam logic [LVL_W-1:0] NEG = LVL_W'(-LEVEL);

  logic [WORD_W-1:0] word_sh;
  logic [CNT_W-1:0]  word_left;
  logic [1:0]        pil_bits;
  logic [1:0]        pil_cnt;
  logic [SLOT_W-1:0] slot;
  logic              pilot_slot, out_hs, bit_i, bit_q;

  assign pilot_slot   = (slot == '0);
  assign word_ready   = (word_left == '0);
  assign ref_ready    = (pil_cnt != 2'd2);
  assign sym_valid    = pilot_slot ? (pil_cnt == 2'd2) : (word_left != '0);
  assign sym_is_pilot = pilot_slot;
  assign out_hs       = sym_valid && sym_ready;
  assign bit_i        = pilot_slot ? pil_bits[0] : word_sh[WORD_W-1];
  assign bit_q        = pilot_slot ? pil_bits[1] : word_sh[WORD_W-2];
  assign sym_re       = bit_i ? NEG : POS;
  assign sym_im       = bit_q ? NEG : POS;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_left <= '0;
      pil_cnt   <= '0;
      slot      <= '0;
    end else begin
      if (word_valid && word_ready) begin
        word_sh   <= word_data;
        word_left <= CNT_W'(SYMS);
      end else if (out_hs && !pilot_slot) begin
        word_sh   <= word_sh << 2;
        word_left <= word_left - 1'b1;
      end
      if (out_hs && pilot_slot) begin
        pil_cnt <= '0;
      end else if (ref_valid && ref_ready) begin
        pil_bits[pil_cnt[0]] <= ref_bit;
        pil_cnt              <= pil_cnt + 1'b1;
      end
      if (out_hs)
        slot <= (slot == SLOT_W'(DATA_RUN)) ? '0 : slot + 1'b1;
    end
  end

  // R7
  hold_while_stalled_chk: assert property (@(posedge clk) disable iff (rst)
    sym_valid && !sym_ready |=> sym_valid && $stable(sym_re) && $stable(sym_im) && $stable(sym_is_pilot));

  // R2
  level_set_chk: assert property (@(posedge clk) disable iff (rst)
    sym_valid |-> (sym_re == POS || sym_re == NEG) && (sym_im == POS || sym_im == NEG));

  // R5
  word_busy_chk: assert property (@(posedge clk) disable iff (rst)
    sym_valid && !sym_is_pilot |-> !word_ready);

  // R9
  ref_release_chk: assert property (@(posedge clk) disable iff (rst)
    sym_valid && sym_ready && sym_is_pilot |=> ref_ready && !sym_is_pilot);

  // R8
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> !sym_valid && word_ready && ref_ready);
endmodule

// File: tb/qpsk_pilot_mux_bench.sv
module qpsk_pilot_mux_bench;
  localparam int L = 23170;
  localparam int NW = 4;
  localparam int NOUT = 77;
  localparam logic [31:0] WORDS [NW] = '{32'hC3A5_0F96, 32'h0000_0000, 32'hFFFF_FFFF, 32'h1234_ABCD};
  localparam logic [31:0] REFS = 32'h2D6B_93C5;

  logic clk = 0, rst = 1;
  logic word_valid = 0, ref_valid = 0, ref_bit = 0, sym_ready = 0;
  logic [31:0] word_data = '0;
  logic word_ready, ref_ready, sym_valid, sym_is_pilot;
  logic [15:0] sym_re, sym_im;

  int checks = 0, fails = 0, n = 0, dcnt = 0, wacc = 0, cyc = 0;
  bit mon_en = 0, auto_rdy = 0, man_rdy = 0, done = 0, stall_prev = 0;
  logic [15:0] p_re, p_im;
  logic p_pil;
  int pi, di, ki, e_re, e_im;
  logic ebi, ebq, e_pil;
  logic [31:0] w;

  always #5 clk = ~clk;

  qpsk_pilot_mux u_qpsk_pilot_mux (
    .clk(clk), .rst(rst), .word_valid(word_valid), .word_data(word_data), .word_ready(word_ready),
    .ref_valid(ref_valid), .ref_bit(ref_bit), .ref_ready(ref_ready), .sym_valid(sym_valid),
    .sym_re(sym_re), .sym_im(sym_im), .sym_is_pilot(sym_is_pilot), .sym_ready(sym_ready));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int lvl(input logic b);
    return b ? -L : L;
  endfunction

  task automatic send_word(input logic [31:0] d);
    @(negedge clk);
    word_valid = 1; word_data = d;
    #1;
    while (!word_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    word_valid = 0;
  endtask

  task automatic send_ref(input logic b);
    @(negedge clk);
    ref_valid = 1; ref_bit = b;
    #1;
    while (!ref_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    ref_valid = 0;
  endtask

  always @(negedge clk) begin
    cyc <= cyc + 1;
    sym_ready <= auto_rdy ? ((cyc % 3) != 2 && (cyc % 7) != 4) : man_rdy;
  end

  always @(negedge clk) begin
    #1;
    if (mon_en) begin
      if (stall_prev)
        check(sym_valid && sym_re == p_re && sym_im == p_im && sym_is_pilot == p_pil,
              "R7 hold", int'($signed(sym_re)), int'($signed(p_re)));
      check(word_ready == (dcnt == 16 * wacc), "R5 word_ready", int'(word_ready), int'(dcnt == 16 * wacc));
      if (sym_valid && sym_ready) begin
        pi = n / 6;
        e_pil = (n % 6 == 0);
        if (e_pil) begin
          ebi = REFS[2*pi]; ebq = REFS[2*pi+1];
        end else begin
          di = n - pi - 1; ki = di % 16; w = WORDS[di/16];
          ebi = w[31-2*ki]; ebq = w[30-2*ki];
          dcnt++;
        end
        e_re = lvl(ebi); e_im = lvl(ebq);
        check(sym_is_pilot == e_pil, "R4/R6 order", int'(sym_is_pilot), int'(e_pil));
        check(int'($signed(sym_re)) == e_re, e_pil ? "R3 pilot I" : "R1/R2 data I", int'($signed(sym_re)), e_re);
        check(int'($signed(sym_im)) == e_im, e_pil ? "R3 pilot Q" : "R1/R2 data Q", int'($signed(sym_im)), e_im);
        n++;
      end
      if (word_valid && word_ready) wacc++;
      stall_prev = sym_valid && !sym_ready;
      p_re = sym_re; p_im = sym_im; p_pil = sym_is_pilot;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R4 watchdog actual=%0d expected=%0d", n, NOUT);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int guard;
    repeat (3) @(negedge clk);
    #1;
    check(!sym_valid && word_ready && ref_ready, "R8 reset state", int'(sym_valid), 0);
    @(negedge clk);
    rst = 0; mon_en = 1; auto_rdy = 1;
    fork
      begin
        for (int i = 0; i < NW; i++) send_word(WORDS[i]);
      end
      begin
        for (int b = 0; b < 26; b++) begin
          if (b == 6) begin
            repeat (35) @(negedge clk);
            #1;
            check(!sym_valid, "R6 pilot stall", int'(sym_valid), 0);
            repeat (5) @(negedge clk);
          end
          send_ref(REFS[b]);
        end
      end
    join
    guard = 0;
    while (n < NOUT && guard < 3000) begin @(negedge clk); guard++; end
    check(n == NOUT, "R4 symbol count", n, NOUT);
    mon_en = 0; auto_rdy = 0; man_rdy = 0;

    // R8: partial pilot bit and held word discarded by reset
    send_ref(1'b1);
    send_word(32'hFFFF_FFFF);
    @(negedge clk); rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    #1;
    check(!sym_valid, "R8 valid after reset", int'(sym_valid), 0);
    check(word_ready, "R8 word_ready after reset", int'(word_ready), 1);
    check(ref_ready, "R8 ref_ready after reset", int'(ref_ready), 1);
    send_ref(1'b0);
    send_ref(1'b1);
    #1;
    check(!ref_ready, "R9 ref_ready while full", int'(ref_ready), 0);
    check(sym_valid && sym_is_pilot, "R8 pilot first", int'(sym_is_pilot), 1);
    send_word(32'h0000_0000);
    #1;
    check(int'($signed(sym_re)) == L, "R3 pilot I after reset", int'($signed(sym_re)), L);
    check(int'($signed(sym_im)) == -L, "R3 pilot Q after reset", int'($signed(sym_im)), -L);
    man_rdy = 1;
    @(negedge clk); #1;
    check(sym_ready && sym_valid && sym_is_pilot, "R7 pilot held", int'(sym_is_pilot), 1);
    @(negedge clk); #1;
    check(ref_ready, "R9 ref_ready after pilot", int'(ref_ready), 1);
    check(sym_valid && !sym_is_pilot, "R4 data after pilot", int'(sym_is_pilot), 0);
    check(int'($signed(sym_re)) == L && int'($signed(sym_im)) == L, "R8 new word data",
          int'($signed(sym_re)), L);
    man_rdy = 0;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule